// File: doc/BRIEF.md
# Interrupt Request Collector with Configurable Pin

This block gathers interrupt requests for a full-speed USB peripheral controller into two request registers. One register takes bus-level events, such as bus supply arrival and loss. The other takes endpoint events, such as buffer-available, data-available and setup-data-available. Each request register has its own enable register. A single interrupt pin is driven whenever at least one enabled request is pending.

Hardware raises a request bit with a one-cycle event pulse. Software clears a bit by writing a one to its position, and a zero leaves that bit as it is. All four registers are readable at the ports.

The pin has two modes. In level mode it is an active-low open-drain output, which allows several devices to share one wired-OR line. In edge mode it is a push-pull output with a selectable active edge. In edge mode a new enabled request always produces a fresh edge, even when other requests are already pending.

Top module: `irq_hub`

## Requirements
- R1: After reset the bus request register reads 0x00, both enable registers read 0x00, and the endpoint request register reads 0x19. The set bits are the buffer-available flags at bit 0 (endpoint 0), bit 3 (endpoint 2) and bit 4 (endpoint 3).
- R2: An event pulse on any bit in one cycle makes the matching request bit read 1 from the next cycle on.
- R3: A request-register write clears each bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit reads 1 afterwards.
- R5: The endpoint setup-data-available request is bit 5 of the endpoint request register.
- R6: In the bus request register, bit 0 is raised by the bus-supply-present event and bit 1 by the bus-supply-lost event.
- R7: An enable-register write loads the write data, which reads back from the next cycle on.
- R8: With `level_mode`=1, `pin_oe`=1 and `pin_out`=0 whenever any request bit is set together with its enable bit; otherwise `pin_oe`=0. The pin follows the register outputs in the same cycle.
- R9: With `level_mode`=0, `pin_oe` is always 1. The active level is high for `edge_pol`=1 and low for `edge_pol`=0. The pin reaches its active level one cycle after an enabled request is first pending, and returns to the inactive level one cycle after none remain.
- R10: In edge mode, when a new enabled request appears while the pin is active, the pin goes inactive for exactly one cycle and then returns to active.
- R11: A request bit whose enable bit is 0 has no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_evt | input | REG_W | Bus event pulses, one per request bit |
| ep_evt | input | REG_W | Endpoint event pulses, one per request bit |
| wdata | input | REG_W | Write data shared by all four registers |
| bus_req_we | input | 1 | Write-one-to-clear strobe for the bus request register |
| bus_en_we | input | 1 | Load strobe for the bus enable register |
| ep_req_we | input | 1 | Write-one-to-clear strobe for the endpoint request register |
| ep_en_we | input | 1 | Load strobe for the endpoint enable register |
| level_mode | input | 1 | 1: open-drain active-low level pin; 0: push-pull edge pin |
| edge_pol | input | 1 | Edge mode only: 1 selects a rising active edge, 0 a falling one |
| bus_req_q | output | REG_W | Bus request register value |
| bus_en_q | output | REG_W | Bus enable register value |
| ep_req_q | output | REG_W | Endpoint request register value |
| ep_en_q | output | REG_W | Endpoint enable register value |
| pin_out | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The assertions check several rules on every cycle:
- an event always leaves its bit set, even against a clearing write;
- a written one with no event clears its bit;
- bits that are neither written nor raised stay unchanged;
- an enable write loads its data;
- in level mode the pin matches the enabled-pending state;
- in edge mode the output enable stays on.

Some behaviour only the bench's scenarios can show. These are the reset values, the fixed bit positions of the setup and bus-supply requests, the exact one-cycle latency of the edge output, and the single inactive cycle inserted when a second request arrives while the pin is already active.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
   // Endpoint request bit positions
   localparam int EP_IN0_BAV_BIT = 0;
   localparam int EP_IN2_BAV_BIT = 3;
   localparam int EP_IN3_BAV_BIT = 4;
   localparam int EP_SETUP_BIT   = 5;
   // Bus request bit positions
   localparam int BUS_SUPPLY_ON_BIT  = 0;
   localparam int BUS_SUPPLY_OFF_BIT = 1;

   typedef enum logic {
      PIN_EDGE  = 1'b0,
      PIN_LEVEL = 1'b1
   } pin_mode_e;
endpackage

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
// One request register plus its enable register.
module irq_bank #(
   parameter int                W       = 8,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] wdata,
   input  logic         req_we,
   input  logic         en_we,
   output logic [W-1:0] req_q,
   output logic [W-1:0] en_q,
   output logic [W-1:0] act
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;
      logic clr;
      assign clr = req_we & wdata[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= RST_VAL[i];
         else        bit_q <= evt[i] | (bit_q & ~clr);   // set wins
      end
      assign req_q[i] = bit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= wdata;
   end

   assign act = req_q & en_q;
endmodule

// File: rtl/irq_pin_drv.sv
`timescale 1ns/1ps
// Pin driver: level (open-drain, active low) or edge (push-pull).
module irq_pin_drv #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] act,
   input  logic         level_mode,
   input  logic         edge_pol,
   output logic         pin_out,
   output logic         pin_oe
);
   import irq_hub_pkg::*;

   logic [N-1:0] prev_q;
   logic         edge_act_q;
   logic         pending;
   logic         fresh;
   logic         edge_act_d;
   pin_mode_e    mode;

   assign mode    = pin_mode_e'(level_mode);
   assign pending = |act;
   assign fresh   = |(act & ~prev_q);
   // Drop for one cycle when a new request appears while already active.
   assign edge_act_d = pending & ~(edge_act_q & fresh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= '0;
         edge_act_q <= 1'b0;
      end else begin
         prev_q     <= act;
         edge_act_q <= edge_act_d;
      end
   end

   always_comb begin
      unique case (mode)
         PIN_LEVEL: begin
            pin_out = 1'b0;
            pin_oe  = pending;
         end
         default: begin
            pin_out = edge_pol ? edge_act_q : ~edge_act_q;
            pin_oe  = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] bus_evt,
   input  logic [REG_W-1:0] ep_evt,
   input  logic [REG_W-1:0] wdata,
   input  logic             bus_req_we,
   input  logic             bus_en_we,
   input  logic             ep_req_we,
   input  logic             ep_en_we,
   input  logic             level_mode,
   input  logic             edge_pol,
   output logic [REG_W-1:0] bus_req_q,
   output logic [REG_W-1:0] bus_en_q,
   output logic [REG_W-1:0] ep_req_q,
   output logic [REG_W-1:0] ep_en_q,
   output logic             pin_out,
   output logic             pin_oe
);
   import irq_hub_pkg::*;

   localparam int N_SRC = 2 * REG_W;
   localparam logic [REG_W-1:0] EP_RST =
      REG_W'((1 << EP_IN0_BAV_BIT) | (1 << EP_IN2_BAV_BIT) | (1 << EP_IN3_BAV_BIT));

   if (REG_W <= EP_SETUP_BIT) begin : g_bad_width
      $error("irq_hub: REG_W must exceed the setup bit position");
   end

   logic [REG_W-1:0] bus_act, ep_act;

   irq_bank #(.W(REG_W), .RST_VAL('0)) u_bus (
      .clk(clk), .rst_n(rst_n), .evt(bus_evt), .wdata(wdata),
      .req_we(bus_req_we), .en_we(bus_en_we),
      .req_q(bus_req_q), .en_q(bus_en_q), .act(bus_act));

   irq_bank #(.W(REG_W), .RST_VAL(EP_RST)) u_ep (
      .clk(clk), .rst_n(rst_n), .evt(ep_evt), .wdata(wdata),
      .req_we(ep_req_we), .en_we(ep_en_we),
      .req_q(ep_req_q), .en_q(ep_en_q), .act(ep_act));

   irq_pin_drv #(.N(N_SRC)) u_pin (
      .clk(clk), .rst_n(rst_n), .act({bus_act, ep_act}),
      .level_mode(level_mode), .edge_pol(edge_pol),
      .pin_out(pin_out), .pin_oe(pin_oe));
endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk #(
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] bus_evt,
   input logic [REG_W-1:0] ep_evt,
   input logic [REG_W-1:0] wdata,
   input logic             bus_req_we,
   input logic             bus_en_we,
   input logic             ep_req_we,
   input logic             ep_en_we,
   input logic             level_mode,
   input logic             edge_pol,
   input logic [REG_W-1:0] bus_req_q,
   input logic [REG_W-1:0] bus_en_q,
   input logic [REG_W-1:0] ep_req_q,
   input logic [REG_W-1:0] ep_en_q,
   input logic             pin_out,
   input logic             pin_oe
);
   logic pend;
   logic [REG_W-1:0] ep_wmask, bus_wmask;
   assign pend      = |(bus_req_q & bus_en_q) | |(ep_req_q & ep_en_q);
   assign ep_wmask  = ep_req_we  ? wdata : '0;
   assign bus_wmask = bus_req_we ? wdata : '0;

   // R2 R4
   ep_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_evt != '0) |=> ((ep_req_q & $past(ep_evt)) == $past(ep_evt)));
   // R2 R4
   bus_evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_evt != '0) |=> ((bus_req_q & $past(bus_evt)) == $past(bus_evt)));
   // R3
   ep_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ep_req_we |=> ((ep_req_q & $past(wdata & ~ep_evt)) == '0));
   // R3
   ep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((ep_req_q ^ $past(ep_req_q)) & ~$past(ep_wmask | ep_evt)) == '0));
   // R3
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((bus_req_q ^ $past(bus_req_q)) & ~$past(bus_wmask | bus_evt)) == '0));
   // R7
   ep_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ep_en_we |=> (ep_en_q == $past(wdata)));
   // R7
   bus_en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en_we |=> (bus_en_q == $past(wdata)));
   // R8 R11
   level_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_mode |-> ((pin_oe == pend) && (!pin_oe || !pin_out)));
   // R9
   edge_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !level_mode |-> pin_oe);
   // R9
   edge_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && !pend) |=> (level_mode || (pin_out != edge_pol)));
endmodule

bind irq_hub irq_hub_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;
   localparam int W = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] bus_evt = '0, ep_evt = '0, wdata = '0;
   logic bus_req_we = 0, bus_en_we = 0, ep_req_we = 0, ep_en_we = 0;
   logic level_mode = 0, edge_pol = 0;
   logic [W-1:0] bus_req_q, bus_en_q, ep_req_q, ep_en_q;
   logic pin_out, pin_oe;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_hub #(.REG_W(W)) dut (.*);

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
      bus_evt = '0; ep_evt = '0;
      bus_req_we = 0; bus_en_we = 0; ep_req_we = 0; ep_en_we = 0;
   endtask

   task automatic clear_all();
      wdata = '1; bus_req_we = 1; ep_req_we = 1;
      step();
   endtask

   task automatic t_reset();
      chk("R1 bus_req", bus_req_q, 8'h00);
      chk("R1 ep_req", ep_req_q, 8'h19);
      chk("R1 bus_en", bus_en_q, 8'h00);
      chk("R1 ep_en", ep_en_q, 8'h00);
      chk("R9 oe", W'(pin_oe), W'(1'b1));
      chk("R9 idle falling pol", W'(pin_out), W'(1'b1));
   endtask

   task automatic t_set_clear();
      ep_evt = 8'h20; step();
      chk("R5 setup bit", ep_req_q, 8'h39);
      bus_evt = 8'h01; step();
      chk("R6 supply on", bus_req_q, 8'h01);
      bus_evt = 8'h02; step();
      chk("R6 supply off", bus_req_q, 8'h03);
      wdata = 8'h20; ep_req_we = 1; step();
      chk("R3 clear one", ep_req_q, 8'h19);
      wdata = 8'h00; ep_req_we = 1; step();
      chk("R3 zero keeps", ep_req_q, 8'h19);
      wdata = 8'h81; ep_req_we = 1; ep_evt = 8'h01; step();
      chk("R4 set wins", ep_req_q, 8'h19);
      wdata = 8'h01; bus_req_we = 1; bus_evt = 8'h40; step();
      chk("R2 R3 bus", bus_req_q, 8'h42);
   endtask

   task automatic t_enable();
      wdata = 8'hA5; bus_en_we = 1; step();
      chk("R7 bus_en", bus_en_q, 8'hA5);
      wdata = 8'h3C; ep_en_we = 1; step();
      chk("R7 ep_en", ep_en_q, 8'h3C);
      wdata = 8'h00; bus_en_we = 1; ep_en_we = 1; step();
      chk("R7 zero", ep_en_q | bus_en_q, 8'h00);
   endtask

   task automatic t_level();
      level_mode = 1; clear_all();
      wdata = 8'h20; ep_en_we = 1; step();
      ep_evt = 8'h02; step();
      chk("R11 disabled req", W'(pin_oe), W'(1'b0));
      ep_evt = 8'h20; step();
      chk("R8 oe", W'(pin_oe), W'(1'b1));
      chk("R8 low", W'(pin_out), W'(1'b0));
      wdata = 8'h20; ep_req_we = 1; step();
      chk("R8 released", W'(pin_oe), W'(1'b0));
   endtask

   task automatic t_edge();
      level_mode = 0; edge_pol = 1; clear_all();
      wdata = 8'h30; ep_en_we = 1; step();
      step();
      chk("R9 idle low", W'(pin_out), W'(1'b0));
      ep_evt = 8'h10; step();
      chk("R9 lag", W'(pin_out), W'(1'b0));
      step();
      chk("R9 active", W'(pin_out), W'(1'b1));
      ep_evt = 8'h20; step();
      chk("R10 still active", W'(pin_out), W'(1'b1));
      step();
      chk("R10 gap", W'(pin_out), W'(1'b0));
      step();
      chk("R10 re-edge", W'(pin_out), W'(1'b1));
      wdata = 8'h30; ep_req_we = 1; step();
      step();
      chk("R9 back idle", W'(pin_out), W'(1'b0));
      edge_pol = 0; step();
      ep_evt = 8'h10; step(); step();
      chk("R9 falling active", W'(pin_out), W'(1'b0));
      chk("R9 oe edge", W'(pin_oe), W'(1'b1));
      wdata = 8'h10; ep_req_we = 1; step(); step();
      chk("R9 falling idle", W'(pin_out), W'(1'b1));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_set_clear();
      t_enable();
      t_level();
      t_edge();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule